// File: doc/BRIEF.md
# Subtract-and-Halve GCD Engine

This block finds the greatest common divisor of two unsigned integers without any divider. It first removes the factors of two that both operands share, halving both in the same cycle and counting how many times this happens. It then subtracts the smaller working value from the larger, one step per cycle, until the two values meet. The meeting value, shifted left by the halving count, is the result.

A caller waits for `ready`, presents both operands, and pulses `start`. The engine latches the operands in that cycle and ignores its inputs until it finishes. It then raises `done` for one cycle. `result` and `err` stay valid after that until the next accepted request. If either operand is zero, the request ends at once with `err` set and a zero result.

The step sequence is idle, halve, subtract, scale and done. The halving phase is skipped when either operand is odd.

Top module: `gcd_sub_halve`

## Requirements
- R1: After reset, `ready` is 1, `done` is 0, `err` is 0 and `result` is 0.
- R2: For two nonzero operands, the `result` shown with `done` equals their greatest common divisor, and `err` is 0.
- R3: If either operand is zero, the request completes with `err` = 1 and `result` = 0.
- R4: `done` is high for exactly one clock cycle per accepted request.
- R5: `start` is accepted only while `ready` is 1. The operands are latched in that cycle. Changes on `start`, `a_in` or `b_in` while busy have no effect on the result.
- R6: `ready` is 0 from the cycle after an accepted `start` through the `done` cycle.
- R7: `result` and `err` hold their values while idle and no `start` is given.
- R8: When both operands share a factor 2^k, the result carries that factor. For example, 48 and 32 give 16, equal operands give themselves, and 64 and 96 give 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request; taken when `ready` is 1 |
| a_in | input | W | First operand |
| b_in | input | W | Second operand |
| ready | output | 1 | Engine idle and able to accept a request |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last request had a zero operand |
| result | output | W | Greatest common divisor of the last request |

## Verification
The assertions check the handshake shape on every cycle:
- `done` lasts one cycle and never coincides with `ready`.
- An accepted `start` drops `ready` on the next cycle.
- `result` and `err` stay still while idle with no request.
- An error always comes with a zero result, and a good completion is never zero.

Only the bench scenarios show that the value is the true divisor. It compares each result with an independently computed Euclid reference. The bench also shows that the shared power of two is restored, and that operand or `start` activity during a busy run changes nothing.

// File: rtl/gcd_sub_halve.sv
module gcd_sub_halve #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic         ready,
  output logic         done,
  output logic         err,
  output logic [W-1:0] result
);
  localparam int KW = $clog2(W) + 1;

  typedef enum logic [2:0] {S_IDLE, S_HALVE, S_SUB, S_SCALE, S_DONE} st_t;

  st_t          st;
  logic [W-1:0] x, y;
  logic [KW-1:0] k;

  wire          x_gt = x > y;
  wire          eq   = x == y;
  wire [W-1:0]  diff = x_gt ? x - y : y - x;

  assign ready = st == S_IDLE;
  assign done  = st == S_DONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      x      <= '0;
      y      <= '0;
      k      <= '0;
      err    <= 1'b0;
      result <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          x <= a_in;
          y <= b_in;
          k <= '0;
          if (a_in == '0 || b_in == '0) begin
            err    <= 1'b1;
            result <= '0;
            st     <= S_DONE;
          end else begin
            err <= 1'b0;
            st  <= (a_in[0] | b_in[0]) ? S_SUB : S_HALVE;
          end
        end
        S_HALVE: begin
          x <= x >> 1;
          y <= y >> 1;
          k <= k + 1'b1;
          if (x[1] | y[1]) st <= S_SUB;
        end
        S_SUB: begin
          if (eq) st <= S_SCALE;
          else if (x_gt) x <= diff;
          else y <= diff;
        end
        S_SCALE: begin
          result <= x << k;
          st     <= S_DONE;
        end
        S_DONE:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module gcd_sub_halve_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         ready,
  input logic         done,
  input logic         err,
  input logic [W-1:0] result
);
  // R4
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R6
  done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !ready);
  // R6
  accept_drop_chk: assert property (@(posedge clk) disable iff (!rst_n) (ready && start) |=> !ready);
  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !start) |=> ($stable(result) && $stable(err)));
  // R3
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n) (done && err) |-> result == '0);
  // R2
  good_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n) (done && !err) |-> result != '0);
endmodule

bind gcd_sub_halve gcd_sub_halve_chk #(.W(W)) chk (
  .clk(clk), .rst_n(rst_n), .start(start), .ready(ready),
  .done(done), .err(err), .result(result)
);

// File: tb/gcd_sub_halve_test.sv
module gcd_sub_halve_test;
  localparam int W = 8;

  logic clk = 0, rst_n = 0, start = 0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic ready, done, err;
  logic [W-1:0] result;
  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  gcd_sub_halve #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .a_in(a_in), .b_in(b_in),
    .ready(ready), .done(done), .err(err), .result(result)
  );

  function automatic int ref_gcd(int a, int b);
    int t;
    while (b != 0) begin t = a % b; a = b; b = t; end
    return a;
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic run(int a, int b, bit disturb);
    int n;
    int dcnt;
    int exp_r;
    bit exp_e;
    exp_e = (a == 0 || b == 0);
    exp_r = exp_e ? 0 : ref_gcd(a, b);
    @(negedge clk);
    while (!ready) @(negedge clk);
    a_in = a[W-1:0]; b_in = b[W-1:0]; start = 1;
    @(negedge clk);
    start = 0;
    // R6 busy after accept
    check("R6 ready after accept", ready, 0);
    n = 0;
    while (!done && n < 2000) begin
      if (disturb) begin
        // R5 stimulus while busy
        start = 1; a_in = 8'd6; b_in = 8'd9;
      end
      @(negedge clk);
      n++;
    end
    start = 0;
    check("R2/R3 completion seen", done, 1);
    check(exp_e ? "R3 result" : "R2 result", result, exp_r);
    check(exp_e ? "R3 err" : "R2 err", err, exp_e);
    dcnt = 0;
    @(negedge clk);
    // R4 one-cycle pulse
    check("R4 done width", done, 0);
    check("R6 ready after done", ready, 1);
  endtask

  initial begin
    int s;
    s = $urandom(32'd1234);
    #1;
    // R1
    check("R1 ready", ready, 1);
    check("R1 done", done, 0);
    check("R1 err", err, 0);
    check("R1 result", result, 0);
    repeat (2) @(negedge clk);
    rst_n = 1;
    // R8 directed
    run(48, 32, 0);
    run(128, 128, 0);
    run(64, 96, 0);
    run(17, 17, 0);
    run(1, 255, 0);
    run(255, 1, 0);
    run(2, 254, 0);
    // R3
    run(0, 5, 0);
    run(7, 0, 0);
    run(0, 0, 0);
    run(12, 18, 0);
    // R5 busy disturbance
    run(200, 150, 1);
    run(0, 3, 1);
    // R7 hold while idle
    run(36, 60, 0);
    a_in = 8'd5; b_in = 8'd7;
    repeat (5) @(negedge clk);
    check("R7 result held", result, 12);
    check("R7 err held", err, 0);
    for (int i = 0; i < 60; i++) begin
      int a, b;
      a = ($urandom % 255) + 1;
      b = ($urandom % 255) + 1;
      if (i % 4 == 0) begin a = a & 8'hF0; b = b & 8'hF8; if (a == 0) a = 16; if (b == 0) b = 8; end
      run(a, b, i % 7 == 0);
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule